// File: doc/BRIEF.md
# Serial Channel Command/Status Engine

This block is the register-level model of one channel of a two-channel serial controller. Software programs it through a byte-wide register port: a pair of mode registers shares one offset behind a pointer that flips on every access, a command register turns the receiver and transmitter on and off and issues housekeeping commands, a clock-select register picks a whole-character time from one of two rate tables, and a data offset reaches the transmit and receive holding registers. Bit-level framing and parity are not modelled. A byte is treated as one unit that takes one character time.

Bytes from the line enter through a valid/ready input and wait in a small queue. The engine hands them over to the receive holding register no faster than one per character time. A byte written for transmit comes out on a one-cycle strobe one character time later. In loopback mode the byte goes straight back into the receive holding register instead. Two level outputs tell a shared interrupt aggregator that a receive byte or transmit room is pending. Instantiated as the second channel, the engine accepts a transmit write only when data bit 3 is set.

Top module: `ser_chan_engine`

## Requirements
- R1: Offset 0x3 reaches two mode registers through a 1-bit pointer that is 0 after reset. Each read or write of 0x3 accesses the register the pointer selects, and the pointer then toggles.
- R2: A non-zero write to offset 0xB is a command. Bit 0 enables the receiver. Bit 1 disables it and clears RXRDY and rx_int. Bit 2 enables the transmitter and sets TXRDY and TXEMT. Bit 3 disables it and clears TXRDY, TXEMT and tx_int. A disable bit wins over its enable bit, and a zero command changes nothing.
- R3: Command bits 6:4 carry a further command. 1 returns the mode pointer to 0. 2 sets RXRDY and enables the receiver. 3 sets TXRDY and TXEMT and disables the transmitter. 4 clears the overrun, parity and framing flags.
- R4: A read of offset 0x7 returns status: bit 0 RXRDY, bit 2 TXRDY, bit 3 TXEMT, bit 4 overrun, bit 5 parity error, bit 6 framing error, and the other bits 0. After reset the status is 0x00, both interrupts are low, no strobe is emitted and rx_ready is high.
- R5: A write to offset 0x7 sets the character time from bits 7:4. rate_alt picks one of two 13-entry tables in ns: index 12 gives 208333 or 416666, and index 11 gives 833333 in both. The time in cycles is floor(ns*CLK_HZ/1e9), never less than 1. Indices 13 to 15 leave it unchanged. After reset it is 1 ms.
- R6: A write to offset 0xF loads the transmit byte and clears TXRDY, TXEMT and tx_int. Exactly one character time C later, if the transmitter is enabled, TXRDY, TXEMT and tx_int are set and tx_valid pulses for one cycle with the byte. If the transmitter is disabled, the byte is dropped.
- R7: When bits 7:6 of the second mode register are 2'b10, a finished transmit byte is not strobed out. It is placed in the receive holding register, and RXRDY and rx_int are set.
- R8: Incoming bytes wait in a 4-entry queue, and rx_ready is low while it is full. A byte entering an empty queue is handed over C+1 cycles after its acceptance edge. Each following queued byte is handed over exactly C cycles after the previous one.
- R9: A handed-over byte is latched only when the receiver is enabled, and is dropped otherwise. Latching sets RXRDY and rx_int, and also sets overrun if RXRDY was already set.
- R10: A read of offset 0xF returns the receive holding register and clears RXRDY and rx_int.
- R11: With CHAN_B=1, a write to offset 0xF is accepted only when data bit 3 is 1. Any other such write changes nothing. With CHAN_B=0, every data write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on this cycle's edge) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rate_alt | input | 1 | Selects the alternate character-time table |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| rx_int | output | 1 | Receive interrupt pending |
| tx_int | output | 1 | Transmit interrupt pending |

## Verification
Assertions check the invariants on every cycle. Each mode access flips the pointer. A pending transmit interrupt implies TXRDY and TXEMT, and a pending receive interrupt implies RXRDY. A transmit strobe lasts one cycle and never appears in loopback. A data read clears RXRDY, and the queue never pops while empty. Only the bench's scenarios can show what needs chosen stimulus and counted cycles: the exact character-time latency for each table and index, the spacing of queued receive deliveries, overrun from an unread byte, the dropping of bytes while a direction is disabled, and the bit-3 filter of the second channel.

// File: rtl/ser_chan_pkg.sv
// Package: shared offsets, status bit positions, command fields and the
// character-time tables of the serial channel engine.
// Assumes: 4-bit register offsets local to one channel.
package ser_chan_pkg;

    localparam logic [3:0] OFS_MODE = 4'h3;
    localparam logic [3:0] OFS_STAT = 4'h7;   // read: status, write: clock select
    localparam logic [3:0] OFS_CMD  = 4'hB;
    localparam logic [3:0] OFS_DATA = 4'hF;

    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMT = 3;
    localparam int ST_OVR   = 4;

    localparam logic [1:0] LOOP_SEL = 2'b10;
    localparam logic [3:0] RATE_ENTRIES = 4'd13;

    typedef enum logic [2:0] {
        XC_NONE    = 3'd0,
        XC_PTR_RST = 3'd1,
        XC_RX_ON   = 3'd2,
        XC_TX_IDLE = 3'd3,
        XC_ERR_CLR = 3'd4
    } xcmd_e;

    // Character time in ns for a table index; alt picks the second table.
    function automatic logic [31:0] rate_ns(input logic alt, input logic [3:0] idx);
        case (idx)
            4'd0:    return alt ? 32'd106666672 : 32'd160000000;
            4'd1:    return 32'd72727272;
            4'd2:    return 32'd59259260;
            4'd3:    return alt ? 32'd53333336 : 32'd40000000;
            4'd4:    return 32'd26666668;
            4'd5:    return 32'd13333334;
            4'd6:    return 32'd6666667;
            4'd7:    return alt ? 32'd4000000 : 32'd7619047;
            4'd8:    return 32'd3333333;
            4'd9:    return 32'd1666666;
            4'd10:   return alt ? 32'd4444444 : 32'd1111111;
            4'd11:   return 32'd833333;
            4'd12:   return alt ? 32'd416666 : 32'd208333;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/ser_char_timer.sv
// Module: one-shot character timer. A start loads len and done rises
// len cycles after the start edge, for one cycle.
// Assumes: len is at least 1; a start while busy restarts the count.
module ser_char_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    // Load on start, otherwise count down to zero and go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= len - 1'b1;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TMR_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> len != '0); // R5

endmodule

// File: rtl/ser_rx_fifo.sv
// Module: small receive byte queue with occupancy count.
// Assumes: push is never asserted while full, pop never while empty.
module ser_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    assign dout  = mem[rd_ptr];
    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_FIFO_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
    AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8

endmodule

// File: rtl/ser_chan_engine.sv
// Module: serial channel command/status engine (top). Holds the mode pair,
// command decoder, status flags, character time and holding registers,
// paces transmit and receive by whole character times, supports loopback.
// Assumes: reg_wr and reg_rd are not asserted together; read side effects
// take place on the edge that ends the read cycle.
module ser_chan_engine
    import ser_chan_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter bit          CHAN_B    = 1'b0,
    parameter int          RXQ_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rate_alt,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       rx_int,
    output logic       tx_int
);

    localparam longint unsigned MAX_CYC = (64'd160000000 * 64'(CLK_HZ)) / 64'd1000000000;
    localparam int              CNT_W   = $clog2(MAX_CYC + 2);
    localparam longint unsigned RST_RAW = 64'(CLK_HZ) / 64'd1000;
    localparam logic [CNT_W-1:0] RST_LEN = (RST_RAW == 0) ? CNT_W'(1) : CNT_W'(RST_RAW);
    localparam int              QC_W    = $clog2(RXQ_DEPTH + 1);

    // Convert a table entry in ns into clock cycles, at least one.
    function automatic logic [CNT_W-1:0] to_cycles(input logic [31:0] ns);
        longint unsigned c;
        c = (64'(ns) * 64'(CLK_HZ)) / 64'd1000000000;
        if (c == 0) c = 1;
        return CNT_W'(c);
    endfunction

    logic [7:0]       mode_q [2];
    logic             mode_ptr;
    logic [CNT_W-1:0] char_len;
    logic             rx_en, tx_en;
    logic             st_rxrdy, st_txrdy, st_txemt, st_ovr;
    logic [7:0]       rx_hold, tx_hold;
    logic             rx_int_q, tx_int_q, tx_valid_q;
    logic [7:0]       tx_data_q;

    logic             acc_mode, wr_clk, wr_cmd, wr_data, rd_data, data_ok;
    xcmd_e            xcmd;
    logic             loop;
    logic             tx_busy, tx_done, tx_fire;
    logic             rx_busy, rx_done, rx_start, latch_ok;
    logic             fifo_push, fifo_full, fifo_empty;
    logic [7:0]       fifo_dout;
    logic [QC_W-1:0]  fifo_count;
    logic [7:0]       status;

    // Second-channel variant filters transmit writes on data bit 3.
    generate
        if (CHAN_B) begin : g_tx_filter
            assign data_ok = reg_wdata[3];
        end else begin : g_tx_open
            assign data_ok = 1'b1;
        end
    endgenerate

    // Register access decode.
    assign acc_mode = (reg_wr || reg_rd) && (reg_addr == OFS_MODE);
    assign wr_clk   = reg_wr && (reg_addr == OFS_STAT);
    assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD) && (reg_wdata != 8'h00);
    assign wr_data  = reg_wr && (reg_addr == OFS_DATA) && data_ok;
    assign rd_data  = reg_rd && (reg_addr == OFS_DATA);
    assign xcmd     = xcmd_e'(reg_wdata[6:4]);
    assign loop     = (mode_q[1][7:6] == LOOP_SEL);

    assign status = {1'b0, 1'b0, 1'b0, st_ovr, st_txemt, st_txrdy, 1'b0, st_rxrdy};

    // Read data mux.
    always_comb begin
        case (reg_addr)
            OFS_MODE: reg_rdata = mode_q[mode_ptr];
            OFS_STAT: reg_rdata = status;
            OFS_DATA: reg_rdata = rx_hold;
            default:  reg_rdata = 8'h00;
        endcase
    end

    // Transmit character timer.
    ser_char_timer #(.CNT_W(CNT_W)) u_tx_tmr (
        .clk(clk), .rst_n(rst_n), .start(wr_data), .len(char_len),
        .busy(tx_busy), .done(tx_done)
    );
    assign tx_fire = tx_done && tx_en;

    // Receive queue and pacing timer.
    assign fifo_push = rx_valid && !fifo_full;
    assign rx_ready  = !fifo_full;

    ser_rx_fifo #(.DEPTH(RXQ_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(rx_byte),
        .pop(rx_done), .dout(fifo_dout), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign rx_start = (!rx_busy && !fifo_empty) || (rx_done && (fifo_count > QC_W'(1)));

    ser_char_timer #(.CNT_W(CNT_W)) u_rx_tmr (
        .clk(clk), .rst_n(rst_n), .start(rx_start), .len(char_len),
        .busy(rx_busy), .done(rx_done)
    );
    assign latch_ok = rx_done && rx_en;

    // Mode pair and its access pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q[0] <= 8'h00;
            mode_q[1] <= 8'h00;
            mode_ptr  <= 1'b0;
        end else if (acc_mode) begin
            if (reg_wr) mode_q[mode_ptr] <= reg_wdata;
            mode_ptr <= ~mode_ptr;
        end else if (wr_cmd && xcmd == XC_PTR_RST) begin
            mode_ptr <= 1'b0;
        end
    end

    // Character time from the clock-select write; invalid indices ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_len <= RST_LEN;
        end else if (wr_clk && reg_wdata[7:4] < RATE_ENTRIES) begin
            char_len <= to_cycles(rate_ns(rate_alt, reg_wdata[7:4]));
        end
    end

    // Status, enables, holding registers and interrupts; later updates win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en <= 1'b0;  tx_en <= 1'b0;
            st_rxrdy <= 1'b0; st_txrdy <= 1'b0; st_txemt <= 1'b0; st_ovr <= 1'b0;
            rx_hold <= 8'h00; tx_hold <= 8'h00;
            rx_int_q <= 1'b0; tx_int_q <= 1'b0;
            tx_valid_q <= 1'b0; tx_data_q <= 8'h00;
        end else begin
            tx_valid_q <= 1'b0;
            if (tx_fire) begin
                st_txrdy <= 1'b1; st_txemt <= 1'b1; tx_int_q <= 1'b1;
                if (loop) begin
                    rx_hold  <= tx_hold;
                    if (st_rxrdy) st_ovr <= 1'b1;
                    st_rxrdy <= 1'b1;
                    rx_int_q <= 1'b1;
                end else begin
                    tx_valid_q <= 1'b1;
                    tx_data_q  <= tx_hold;
                end
            end
            if (wr_data) begin
                tx_hold  <= reg_wdata;
                st_txrdy <= 1'b0; st_txemt <= 1'b0; tx_int_q <= 1'b0;
            end
            if (wr_cmd) begin
                if (reg_wdata[3]) begin
                    tx_en <= 1'b0; st_txrdy <= 1'b0; st_txemt <= 1'b0; tx_int_q <= 1'b0;
                end else if (reg_wdata[2]) begin
                    tx_en <= 1'b1; st_txrdy <= 1'b1; st_txemt <= 1'b1;
                end
                if (reg_wdata[1]) begin
                    rx_en <= 1'b0; st_rxrdy <= 1'b0; rx_int_q <= 1'b0;
                end else if (reg_wdata[0]) begin
                    rx_en <= 1'b1;
                end
                case (xcmd)
                    XC_RX_ON:   begin st_rxrdy <= 1'b1; rx_en <= 1'b1; end
                    XC_TX_IDLE: begin st_txrdy <= 1'b1; st_txemt <= 1'b1; tx_en <= 1'b0; end
                    XC_ERR_CLR: st_ovr <= 1'b0;
                    default:    ;
                endcase
            end
            if (rd_data) begin
                st_rxrdy <= 1'b0; rx_int_q <= 1'b0;
            end
            if (latch_ok) begin
                rx_hold  <= fifo_dout;
                if (st_rxrdy) st_ovr <= 1'b1;
                st_rxrdy <= 1'b1;
                rx_int_q <= 1'b1;
            end
        end
    end

    assign tx_valid = tx_valid_q;
    assign tx_data  = tx_data_q;
    assign rx_int   = rx_int_q;
    assign tx_int   = tx_int_q;

    AST_MODE_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mode |=> mode_ptr != $past(mode_ptr)); // R1
    AST_TXINT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |-> (st_txrdy && st_txemt)); // R6
    AST_TX_TIMER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> tx_busy); // R6
    AST_TX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R6
    AST_LOOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(mode_q[1][7:6]) != LOOP_SEL); // R7
    AST_RXINT_RXRDY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |-> st_rxrdy); // R9
    AST_RDDATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !latch_ok && !(tx_fire && loop)) |=> !st_rxrdy); // R10

endmodule

// File: tb/ser_chan_engine_tb.sv
// Bench: scoreboard for transmit strobes (driver queues expected byte and
// cycle, monitor compares), directed register scenarios for the rest.
module ser_chan_engine_tb;

    localparam int unsigned SIM_HZ = 1_000_000;
    localparam int C_A12 = 208;
    localparam int C_B12 = 416;
    localparam int C_11  = 833;

    typedef struct { logic [7:0] b; int at; } tx_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic       rate_alt = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    logic [7:0] rdata_a, rdata_b, bus_rdata;
    logic       rx_ready_a, tx_valid_a, rx_int_a, tx_int_a;
    logic       rx_ready_b, tx_valid_b, rx_int_b, tx_int_b;
    logic [7:0] tx_data_a, tx_data_b;
    logic       wr_a, rd_a, wr_b, rd_b;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done_run = 1'b0;
    tx_item_t sb_a[$];
    tx_item_t sb_b[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign wr_a = bus_wr && !bus_sel;
    assign rd_a = bus_rd && !bus_sel;
    assign wr_b = bus_wr && bus_sel;
    assign rd_b = bus_rd && bus_sel;
    assign bus_rdata = bus_sel ? rdata_b : rdata_a;

    ser_chan_engine #(.CLK_HZ(SIM_HZ), .CHAN_B(1'b0), .RXQ_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_rd(rd_a), .reg_addr(bus_addr),
        .reg_wdata(bus_wdata), .reg_rdata(rdata_a), .rate_alt(rate_alt),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready_a),
        .tx_valid(tx_valid_a), .tx_data(tx_data_a), .rx_int(rx_int_a), .tx_int(tx_int_a)
    );

    ser_chan_engine #(.CLK_HZ(SIM_HZ), .CHAN_B(1'b1), .RXQ_DEPTH(4)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_rd(rd_b), .reg_addr(bus_addr),
        .reg_wdata(bus_wdata), .reg_rdata(rdata_b), .rate_alt(rate_alt),
        .rx_valid(1'b0), .rx_byte(8'h00), .rx_ready(rx_ready_b),
        .tx_valid(tx_valid_b), .tx_data(tx_data_b), .rx_int(rx_int_b), .tx_int(tx_int_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Register write, called at a negedge; returns at the next negedge.
    task automatic wr(input logic sel, input logic [3:0] a, input logic [7:0] d);
        bus_sel = sel; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Register read, called at a negedge; value sampled before the edge.
    task automatic rd(input logic sel, input logic [3:0] a, output logic [7:0] d);
        bus_sel = sel; bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic sel, input logic [3:0] a,
                          input logic [7:0] exp);
        logic [7:0] v;
        rd(sel, a, v);
        chk(req, v, exp);
    endtask

    // Driver: queue the expected byte and strobe cycle, then write it.
    task automatic send_tx(input logic sel, input logic [7:0] d, input int len);
        tx_item_t it;
        it.b = d;
        it.at = cyc + 1 + len;
        if (sel) sb_b.push_back(it); else sb_a.push_back(it);
        wr(sel, 4'hF, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push_one(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Monitor: every transmit strobe must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && tx_valid_a) begin
            if (sb_a.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6 unexpected strobe actual=%0h expected=none", tx_data_a);
            end else begin
                tx_item_t it;
                it = sb_a.pop_front();
                chk("R6 strobe byte", tx_data_a, it.b);
                chk("R6 strobe cycle", cyc, it.at);
            end
        end
        if (rst_n && tx_valid_b) begin
            if (sb_b.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected strobe actual=%0h expected=none", tx_data_b);
            end else begin
                tx_item_t it;
                it = sb_b.pop_front();
                chk("R11 strobe byte", tx_data_b, it.b);
                chk("R11 strobe cycle", cyc, it.at);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n, e1;
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R4: reset state
        chk_rd("R4 reset status", 1'b0, 4'h7, 8'h00);
        chk("R4 reset rx_ready", rx_ready_a, 1);
        chk("R4 reset ints", {rx_int_a, tx_int_a}, 0);

        // R1: mode pair behind a toggling pointer
        wr(0, 4'h3, 8'h11);
        wr(0, 4'h3, 8'h22);
        chk_rd("R1 mode first", 0, 4'h3, 8'h11);
        chk_rd("R1 mode second", 0, 4'h3, 8'h22);
        chk_rd("R1 mode wrap", 0, 4'h3, 8'h11);

        // R2: enable/disable commands
        wr(0, 4'hB, 8'h05);
        chk_rd("R2 enable both", 0, 4'h7, 8'h0C);
        wr(0, 4'hB, 8'h0A);
        chk_rd("R2 disable both", 0, 4'h7, 8'h00);
        wr(0, 4'hB, 8'h0F);
        chk_rd("R2 disable wins", 0, 4'h7, 8'h00);
        wr(0, 4'hB, 8'h05);
        wr(0, 4'hB, 8'h00);
        chk_rd("R2 zero command", 0, 4'h7, 8'h0C);

        // R5/R6: character time index 12, primary table
        wr(0, 4'h7, 8'hC0);
        send_tx(0, 8'h5A, C_A12);
        chk_rd("R6 write clears flags", 0, 4'h7, 8'h00);
        chk("R6 write clears tx_int", tx_int_a, 0);
        idle(C_A12 + 5);
        chk_rd("R6 flags restored", 0, 4'h7, 8'h0C);
        chk("R6 tx_int raised", tx_int_a, 1);

        // R5: alternate table, ignored index, index 11
        rate_alt = 1'b1;
        wr(0, 4'h7, 8'hC0);
        send_tx(0, 8'hA5, C_B12);
        idle(C_B12 + 5);
        wr(0, 4'h7, 8'hD0);
        send_tx(0, 8'h3C, C_B12);
        idle(C_B12 + 5);
        wr(0, 4'h7, 8'hB0);
        send_tx(0, 8'h11, C_11);
        idle(C_11 + 5);
        rate_alt = 1'b0;
        wr(0, 4'h7, 8'hC0);

        // R6: transmitter disabled drops the byte
        wr(0, 4'hB, 8'h08);
        wr(0, 4'hF, 8'h99);
        idle(C_A12 + 5);
        chk_rd("R6 disabled no flags", 0, 4'h7, 8'h00);
        chk("R6 disabled no tx_int", tx_int_a, 0);

        // R3: command 3 sets flags and leaves transmitter off
        wr(0, 4'hB, 8'h30);
        chk_rd("R3 tx idle flags", 0, 4'h7, 8'h0C);
        wr(0, 4'hF, 8'h42);
        idle(C_A12 + 5);
        chk_rd("R3 tx stays off", 0, 4'h7, 8'h00);

        // R3: command 1 resets the mode pointer (pointer is 1 here)
        wr(0, 4'hB, 8'h10);
        chk_rd("R3 ptr reset", 0, 4'h3, 8'h11);

        // R7: loopback
        wr(0, 4'h3, 8'h80);
        wr(0, 4'hB, 8'h05);
        wr(0, 4'hF, 8'h77);
        idle(C_A12 + 4);
        chk_rd("R7 loopback status", 0, 4'h7, 8'h0D);
        chk("R7 loopback ints", {rx_int_a, tx_int_a}, 2'b11);
        chk_rd("R10 loopback byte", 0, 4'hF, 8'h77);
        chk_rd("R10 read clears RXRDY", 0, 4'h7, 8'h0C);
        chk("R10 read clears rx_int", rx_int_a, 0);
        wr(0, 4'h3, 8'h11);
        wr(0, 4'h3, 8'h00);

        // R11 on channel A: bit 3 clear is still accepted
        send_tx(0, 8'h01, C_A12);
        idle(C_A12 + 5);

        // R8/R9/R10: queued receive pacing
        rx_valid = 1'b1; rx_byte = 8'h61;
        n = cyc;
        @(negedge clk); rx_byte = 8'h62;
        @(negedge clk); rx_byte = 8'h63;
        @(negedge clk); rx_byte = 8'h64;
        @(negedge clk); rx_byte = 8'h65;
        chk("R8 queue full", rx_ready_a, 0);
        e1 = n + 1 + C_A12 + 1;
        wait_cyc(e1 - 1);
        chk("R8 first not early", rx_int_a, 0);
        @(negedge clk);
        chk("R8 first on time", rx_int_a, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        chk_rd("R9 first byte", 0, 4'hF, 8'h61);
        for (int k = 1; k < 4; k++) begin
            wait_cyc(e1 + k * C_A12 - 1);
            chk("R8 spacing not early", rx_int_a, 0);
            @(negedge clk);
            chk("R8 spacing on time", rx_int_a, 1);
            if (k < 3) chk_rd("R10 queued byte", 0, 4'hF, 8'h61 + k[7:0]);
        end
        wait_cyc(e1 + 4 * C_A12 + 1);
        chk_rd("R9 overrun status", 0, 4'h7, 8'h1D);
        chk_rd("R10 latest byte", 0, 4'hF, 8'h65);
        wr(0, 4'hB, 8'h40);
        chk_rd("R3 error clear", 0, 4'h7, 8'h0C);

        // R9: receiver disabled drops; R3 command 2 enables and sets RXRDY
        wr(0, 4'hB, 8'h02);
        push_one(8'h70);
        idle(C_A12 + 10);
        chk_rd("R9 disabled drop", 0, 4'h7, 8'h0C);
        chk("R9 disabled no rx_int", rx_int_a, 0);
        wr(0, 4'hB, 8'h20);
        chk_rd("R3 rx on sets RXRDY", 0, 4'h7, 8'h0D);
        push_one(8'h71);
        idle(C_A12 + 10);
        chk_rd("R9 overrun after cmd2", 0, 4'h7, 8'h1D);
        chk_rd("R3 receiver enabled", 0, 4'hF, 8'h71);
        wr(0, 4'hB, 8'h40);

        // R11: second channel filters on data bit 3
        wr(1, 4'hB, 8'h04);
        wr(1, 4'h7, 8'hC0);
        wr(1, 4'hF, 8'h01);
        chk_rd("R11 filtered write", 1, 4'h7, 8'h0C);
        idle(C_A12 + 5);
        send_tx(1, 8'h09, C_A12);
        chk_rd("R11 accepted write", 1, 4'h7, 8'h00);
        idle(C_A12 + 5);
        chk_rd("R11 flags restored", 1, 4'h7, 8'h0C);

        idle(4);
        chk("R6 all strobes seen", sb_a.size() + sb_b.size(), 0);
        finish_run();
    end

endmodule